// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel with Event Chaining

This block is one timer channel of a timer array. A small register port sets up an operating mode, a clock divider choice, a counter with its reload value, and a run bit. In timer mode the channel decrements once per divided system-clock tick, with a divide ratio of 1, 8 or 32. In event mode it decrements on one of two sources:

- the rising edges of an asynchronous pin, or
- the raw request pulses of a neighbouring timer channel.

The neighbour's pulses count whether or not anything downstream masks them. If that neighbour measures pulse widths or periods, it pulses at the active edge of the measured signal, so the event lands there as well.

When the counter has reached zero, the next counted event reloads it from the reload register. The channel then raises a one-cycle request pulse. Configuration registers accept writes only while the channel is stopped. The read port returns the live count. In the cycle that follows a reload, the read port returns all-ones instead.

Top module: `tmr_chan`

## Requirements
- R1: After reset the run bit, counter, reload value, mode, source select and divider select are all 0, and `irq` is low.
- R2: Writes to address 0 (bit 0 = mode, 0 timer / 1 event; bit 1 = source select, 1 = neighbour pulses) and to address 1 (bits 1:0 = divider, 00 → /1, 01 → /8, 1x → /32) are ignored while the run bit is 1. A read-back of those addresses shows the old values.
- R3: A write to address 2 while stopped loads both the counter and the reload value. A read of address 2 before starting returns the written value.
- R4: A write to address 2 while running changes only the reload value, which the counter takes at its next reload. If the write falls on the same clock edge as a reload, the counter takes the prior reload value.
- R5: While running, a read of address 2 returns the live counter. In the cycle in which `irq` is high, the same read returns all-ones.
- R6: Each counted event decrements a nonzero counter by one. A counted event at zero loads the reload value. On the following cycle `irq` is high for exactly that one cycle.
- R7: In timer mode, one event is counted every N clock cycles (N = 1, 8 or 32). The first event is counted on the Nth clock edge after the edge that sets the run bit. Setting the run bit from 0 to 1 restarts the divider.
- R8: In event mode with source select 0, each rising edge of `ext_evt` is counted after a two-flop synchroniser. A level that is high before clock edge k is counted at edge k+2.
- R9: In event mode with source select 1, each cycle in which `chain_req` is high counts one event at the following clock edge.
- R10: Address 3 bit 0 is the run bit. While it is 0, the counter holds unless address 2 is written. After a restart, counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 mode, 1 divider, 2 count, 3 run) |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | CNT_W | Combinational read data |
| ext_evt | input | 1 | Asynchronous external event input |
| chain_req | input | 1 | One-cycle request pulses of the neighbouring timer |
| irq | output | 1 | One-cycle request pulse after each reload |

## Verification
Two functions can collide in one cycle: a host write to the count register while running, and a reload of the counter. The bench provokes this with small reload values under the /1 divider and with dense neighbour pulses, so that reloads fall every few cycles while random writes land on address 2. Its cycle model lets the coincident edge load the old reload value and keeps the new one for the next wrap. Each cycle it compares the read port, including the all-ones read during the request cycle, and the `irq` pin against that model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      A_MODE  = 2'd0,
      A_DIV   = 2'd1,
      A_COUNT = 2'd2,
      A_RUN   = 2'd3
   } tmr_addr_e;

   localparam int MODE_BIT = 0;
   localparam int SEL_BIT  = 1;
   localparam int RUN_BIT  = 0;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   if (STAGES < 2) begin : g_bad
      $error("tmr_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];

   assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tmr_presc.sv
module tmr_presc #(
   parameter int DIV_MID = 8,
   parameter int DIV_HI  = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       restart,
   input  logic [1:0] sel,
   output logic       tick
);
   localparam int PW = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;

   if (DIV_MID < 2 || DIV_HI <= DIV_MID) begin : g_bad
      $error("tmr_presc: need 2 <= DIV_MID < DIV_HI");
   end

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] lim;

   always_comb begin
      unique casez (sel)
         2'b00:   lim = '0;
         2'b01:   lim = PW'(DIV_MID - 1);
         default: lim = PW'(DIV_HI - 1);
      endcase
   end

   assign tick = run && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (restart)   cnt_q <= '0;
      else if (run)       cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load_cnt,
   input  logic             load_rel,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] rel,
   output logic             wrap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         rel  <= '0;
         wrap <= 1'b0;
      end else begin
         wrap <= tick && (cnt == '0);
         if (tick)          cnt <= (cnt == '0) ? rel : cnt - 1'b1;
         else if (load_cnt) cnt <= wdata;
         if (load_rel)      rel <= wdata;
      end
   end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_MID     = 8,
   parameter int DIV_HI      = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   input  logic             ext_evt,
   input  logic             chain_req,
   output logic             irq
);
   localparam int PAD = CNT_W - 2;

   if (CNT_W < 4) begin : g_bad
      $error("tmr_chan: CNT_W must be at least 4");
   end

   logic             run_q, mode_q, sel_q;
   logic [1:0]       ps_q;
   logic             wr_mode, wr_div, wr_cnt, wr_run, start_rise;
   logic             p_tick, e_rise, tick;
   logic [CNT_W-1:0] cnt_w, rel_w;

   assign wr_mode    = wr_en && (wr_addr == A_MODE);
   assign wr_div     = wr_en && (wr_addr == A_DIV);
   assign wr_cnt     = wr_en && (wr_addr == A_COUNT);
   assign wr_run     = wr_en && (wr_addr == A_RUN);
   assign start_rise = wr_run && wr_data[RUN_BIT] && !run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         mode_q <= 1'b0;
         sel_q  <= 1'b0;
         ps_q   <= 2'b00;
      end else begin
         if (wr_run) run_q <= wr_data[RUN_BIT];
         if (wr_mode && !run_q) begin
            mode_q <= wr_data[MODE_BIT];
            sel_q  <= wr_data[SEL_BIT];
         end
         if (wr_div && !run_q) ps_q <= wr_data[1:0];
      end
   end

   tmr_presc #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(run_q), .restart(start_rise),
      .sel(ps_q), .tick(p_tick)
   );

   tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_evt), .rise(e_rise)
   );

   assign tick = run_q && (mode_q ? (sel_q ? chain_req : e_rise) : p_tick);

   tmr_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .load_cnt(wr_cnt && !run_q), .load_rel(wr_cnt), .wdata(wr_data),
      .cnt(cnt_w), .rel(rel_w), .wrap(irq)
   );

   always_comb begin
      unique case (rd_addr)
         A_MODE:  rd_data = {{PAD{1'b0}}, sel_q, mode_q};
         A_DIV:   rd_data = {{PAD{1'b0}}, ps_q};
         A_COUNT: rd_data = irq ? '1 : cnt_w;
         default: rd_data = {{(CNT_W-1){1'b0}}, run_q};
      endcase
   end
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [1:0]       rd_addr,
   input logic [CNT_W-1:0] rd_data,
   input logic             irq,
   input logic             run,
   input logic             mode,
   input logic             sel,
   input logic [1:0]       ps,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] rel
);
   // R5: all-ones read in the request cycle
   p_ones_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && rd_addr == A_COUNT) |-> (rd_data == {CNT_W{1'b1}}));

   // R6: a request follows a wrap from zero into the prior reload value
   p_wrap_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(cnt) == '0 && cnt == $past(rel)));

   // R6: a request is not repeated while the counter is nonzero
   p_single_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && cnt != '0) |=> !irq);

   // R2: configuration frozen while running
   p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run) |-> ($stable(mode) && $stable(sel) && $stable(ps)));

   // R10: stopped counter holds without a count write
   p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!run && !(wr_en && wr_addr == A_COUNT)) |-> $stable(cnt));
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .run(run_q),
   .mode(mode_q), .sel(sel_q), .ps(ps_q), .cnt(cnt_w), .rel(rel_w)
);

// File: tb/sim_tmr_chan.sv
module sim_tmr_chan;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [1:0]   rd_addr = '0;
   logic [W-1:0] rd_data;
   logic         ext_evt = 1'b0;
   logic         chain_req = 1'b0;
   logic         irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // reference model state
   bit         m_run, m_mode, m_sel, m_irq, m_s0, m_s1, m_prev;
   bit [1:0]   m_ps;
   bit [W-1:0] m_cnt, m_rel;
   int         m_pc;

   always #10 clk = ~clk;

   tmr_chan u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .ext_evt(ext_evt), .chain_req(chain_req), .irq(irq)
   );

   function automatic int lim_of(bit [1:0] p);
      return (p == 2'b00) ? 0 : (p == 2'b01) ? 7 : 31;
   endfunction

   function automatic bit [W-1:0] exp_read(bit [1:0] a);
      case (a)
         2'd0:    return {{(W-2){1'b0}}, m_sel, m_mode};
         2'd1:    return {{(W-2){1'b0}}, m_ps};
         2'd2:    return m_irq ? {W{1'b1}} : m_cnt;
         default: return {{(W-1){1'b0}}, m_run};
      endcase
   endfunction

   function automatic string tag_of(bit [1:0] a);
      if (a == 2'd2 && m_irq) return "R5";
      if (a == 2'd0 || a == 2'd1) return "R2";
      if (a == 2'd3 || !m_run) return "R10";
      if (!m_mode) return "R7";
      return m_sel ? "R9" : "R8";
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_mode = 0; m_sel = 0; m_irq = 0; m_ps = 0;
         m_cnt = 0; m_rel = 0; m_pc = 0; m_s0 = 0; m_s1 = 0; m_prev = 0;
      end else begin
         bit ptick, rise, tick, wrc, wrr;
         int lim;
         lim   = lim_of(m_ps);
         ptick = m_run && (m_pc == lim);
         rise  = m_s1 && !m_prev;
         tick  = m_run && (m_mode ? (m_sel ? chain_req : rise) : ptick);
         wrc   = wr_en && wr_addr == 2'd2;
         wrr   = wr_en && wr_addr == 2'd3;
         m_irq = tick && (m_cnt == 0);
         if (tick)             m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 1'b1;
         else if (wrc && !m_run) m_cnt = wr_data;
         if (wrc) m_rel = wr_data;
         if (wrr && wr_data[0] && !m_run) m_pc = 0;
         else if (m_run) m_pc = (m_pc == lim) ? 0 : m_pc + 1;
         if (wr_en && wr_addr == 2'd0 && !m_run) begin
            m_mode = wr_data[0]; m_sel = wr_data[1];
         end
         if (wr_en && wr_addr == 2'd1 && !m_run) m_ps = wr_data[1:0];
         if (wrr) m_run = wr_data[0];
         m_prev = m_s1; m_s1 = m_s0; m_s0 = ext_evt;
      end
   end

   task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tag_of(rd_addr), rd_data, exp_read(rd_addr));
         check("R6", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_irq});
      end
   end

   task automatic wr(bit [1:0] a, bit [W-1:0] d);
      @(posedge clk); #2;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
      end
   endtask

   task automatic peek(bit [1:0] a, bit [W-1:0] exp, string tag);
      @(posedge clk); #2;
      rd_addr = a;
      @(negedge clk);
      check(tag, rd_data, exp);
   endtask

   initial begin
      void'($urandom(32'h5eed_7a1e));
      idle(0);
      #35 rst_n = 1'b1;
      // R1: reset values
      peek(2'd0, 16'h0000, "R1");
      peek(2'd1, 16'h0000, "R1");
      peek(2'd2, 16'h0000, "R1");
      peek(2'd3, 16'h0000, "R1");
      check("R1", {15'd0, irq}, 16'd0);
      // R3: stopped write loads counter and reads back
      wr(2'd2, 16'd5);
      peek(2'd2, 16'd5, "R3");
      // R7: /8 timer run; model comparison covers timing
      wr(2'd1, 16'd1);
      wr(2'd3, 16'd1);
      // R2: writes while running are ignored
      wr(2'd0, 16'd3);
      wr(2'd1, 16'd2);
      peek(2'd0, 16'd0, "R2");
      peek(2'd1, 16'd1, "R2");
      // R4: reload changed while running
      wr(2'd2, 16'd2);
      idle(150);
      // R10: stop holds, restart resumes
      wr(2'd3, 16'd0);
      idle(20);
      wr(2'd3, 16'd1);
      idle(40);
      wr(2'd3, 16'd0);
      // R9: neighbour pulses in event mode
      wr(2'd0, 16'd3);
      wr(2'd2, 16'd1);
      wr(2'd3, 16'd1);
      for (int i = 0; i < 40; i++) begin
         @(posedge clk); #2;
         chain_req = i[0];
         rd_addr = 2'd2;
      end
      chain_req = 1'b0;
      wr(2'd3, 16'd0);
      // R8: external edges in event mode
      wr(2'd0, 16'd1);
      wr(2'd3, 16'd1);
      for (int i = 0; i < 60; i++) begin
         @(posedge clk); #2;
         ext_evt = i[2];
      end
      wr(2'd3, 16'd0);
      // random phase with small reloads so wraps and writes collide
      for (int i = 0; i < 6000; i++) begin
         @(posedge clk); #2;
         rd_addr   = 2'($urandom);
         chain_req = ($urandom % 3) == 0;
         ext_evt   = ($urandom % 4) == 0 ? ~ext_evt : ext_evt;
         wr_en     = ($urandom % 6) == 0;
         wr_addr   = 2'($urandom);
         wr_data   = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom % 5);
         if (wr_addr == 2'd3 && ($urandom % 4) != 0) wr_data[0] = 1'b1;
      end
      wr_en = 1'b0;
      idle(4);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule